// File: doc/BRIEF.md
# Multiplexed External Bus Cycle Sequencer

This block runs one bus cycle at a time on an external bus whose low address byte and data byte share the same eight wires. It produces the address-latch strobe, the active-low code-fetch strobe and the active-low read and write strobes. It also produces the drive enable and drive value for the shared wires, the high address byte, the byte captured from the bus, and a one-clock completion pulse. Every edge sits at a fixed offset counted in oscillator clock periods. In this description, phase 0 is the first clock after the edge that accepts a request, and each later clock raises the phase by one.

The requester presents a kind, a 16-bit address, a write byte and a latch-suppress bit. A request is taken only while the block is idle. There are four kinds, encoded 0 for an internal code fetch, 1 for an external code fetch, 2 for an external data read and 3 for an external data write. An internal fetch keeps the shared wires and the fetch strobe quiet. It pulses the address-latch strobe only when suppression is off. Suppression, sampled when the request is taken, silences the latch strobe during internal fetches only. Every external cycle pulses it regardless.

Top module: `ebus_seq`

## Requirements
- R1: After reset and while idle, `ale` is 0, `psen_n`, `rd_n` and `wr_n` are 1, `ad_oe` is 0 and `done` is 0.
- R2: `ale` is 1 in phases 0 and 1 of a cycle that pulses it, and 0 in every other phase.
- R3: In external cycles (kinds 1, 2 and 3), `ad_oe` is 1 and `ad_out` carries address bits 7:0 in phases 0 to 2, which is one clock past the fall of `ale`.
- R4: `psen_n` is 0 in phases 3, 4 and 5 of an external code fetch (kind 1) only. It stays 1 for an internal fetch (kind 0), and the shared wires are not driven during phases 3 to 5.
- R5: An external code fetch loads `ad_in` into `rdata` at the clock edge that ends phase 5.
- R6: `rd_n` is 0 in phases 5 to 10 of a data read (kind 2), and `rdata` takes `ad_in` at the edge that ends phase 10. `ad_oe` is 0 while `rd_n` is 0.
- R7: `wr_n` is 0 in phases 5 to 10 of a data write (kind 3). `ad_out` carries the write byte with `ad_oe` at 1 in phases 4 to 11, and the wires are released in phase 3.
- R8: With `ale_off` at 1 when the request is taken, an internal fetch leaves `ale` at 0 throughout. External cycles pulse `ale` whatever `ale_off` is, and with `ale_off` at 0 an internal fetch also pulses it.
- R9: `addr_hi` equals address bits 15:8 throughout an external cycle.
- R10: `done` is 1 for exactly one clock, in phase 6 for a fetch (kinds 0 and 1) and in phase 11 for a data cycle (kinds 2 and 3), and the block is idle in the next clock.
- R11: A request raised while a cycle is running changes no output of that cycle and is not taken.
- R12: Internal fetches and data writes leave `rdata` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock, one period per timing unit |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present, taken when idle |
| req_kind | input | 2 | 0 internal fetch, 1 external fetch, 2 data read, 3 data write |
| req_addr | input | 16 | Cycle address |
| req_wdata | input | 8 | Byte to write |
| ale_off | input | 1 | Suppress the latch strobe for internal fetches |
| ad_in | input | 8 | Value read from the shared wires |
| ad_out | output | 8 | Value driven on the shared wires |
| ad_oe | output | 1 | Drive enable for the shared wires |
| addr_hi | output | 8 | High address byte |
| ale | output | 1 | Address-latch strobe, active high |
| psen_n | output | 1 | Code-fetch strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| rdata | output | 8 | Byte captured from the bus |
| done | output | 1 | One-clock pulse in the last phase |

## Verification
The bench runs every kind with suppression both on and off over addresses that include all-zeros and all-ones. It checks every output in every phase against windows worked out from the clock offsets. An off-by-one window would show up on a strobe edge a clock early or late, or on an address or write byte released one clock too soon. A wrong capture edge would leave `rdata` at a stale byte. A suppress bit applied to external cycles would lose their `ale` pulse. In some runs a second request with a different kind and address arrives mid-cycle. A sequencer that took it would corrupt `addr_hi` or the strobe pattern.

// File: rtl/ebus_pkg.sv
// Shared types for the external bus sequencer.
// Assumes the kind encoding is fixed at two bits.
package ebus_pkg;
    typedef enum logic [1:0] {
        BK_INT_FETCH = 2'd0,
        BK_EXT_FETCH = 2'd1,
        BK_DATA_RD   = 2'd2,
        BK_DATA_WR   = 2'd3
    } bus_kind_t;
endpackage

// File: rtl/ebus_phase_ctr.sv
// Phase counter: takes a request when idle, counts clock periods and
// flags the final phase. Assumes LAST_FETCH and LAST_DATA fit in PH_W bits.
module ebus_phase_ctr
    import ebus_pkg::*;
#(
    parameter int PH_W       = 4,
    parameter int LAST_FETCH = 6,
    parameter int LAST_DATA  = 11
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            accept,
    input  bus_kind_t       req_kind,
    input  logic            req_off,
    output logic            busy,
    output logic [PH_W-1:0] phase,
    output bus_kind_t       kind,
    output logic            off_q,
    output logic            last
);
    localparam logic [PH_W-1:0] P_LAST_F = PH_W'(LAST_FETCH);
    localparam logic [PH_W-1:0] P_LAST_D = PH_W'(LAST_DATA);

    logic is_fetch;

    // Fetch kinds end earlier than data kinds.
    always_comb begin
        is_fetch = (kind == BK_INT_FETCH) || (kind == BK_EXT_FETCH);
        last     = busy && (phase == (is_fetch ? P_LAST_F : P_LAST_D));
    end

    // Cycle state: start on accept, advance each clock, stop after the last phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            phase <= '0;
            kind  <= BK_INT_FETCH;
            off_q <= 1'b0;
        end else if (!busy) begin
            if (accept) begin
                busy  <= 1'b1;
                phase <= '0;
                kind  <= req_kind;
                off_q <= req_off;
            end
        end else if (last) begin
            busy  <= 1'b0;
            phase <= '0;
        end else begin
            phase <= phase + PH_W'(1);
        end
    end
endmodule

// File: rtl/ebus_strobe_gen.sv
// Strobe decoder: turns phase and kind into strobes and drive selects.
// Each window is [on, off) in phases. Assumes busy gates all activity.
module ebus_strobe_gen
    import ebus_pkg::*;
#(
    parameter int PH_W       = 4,
    parameter int T_ALE_FALL = 2,
    parameter int T_ADDR_END = 3,
    parameter int T_PSEN_ON  = 3,
    parameter int T_PSEN_OFF = 6,
    parameter int T_RW_ON    = 5,
    parameter int T_RW_OFF   = 11,
    parameter int T_WD_ON    = 4,
    parameter int T_WD_OFF   = 12
) (
    input  logic            busy,
    input  logic [PH_W-1:0] phase,
    input  bus_kind_t       kind,
    input  logic            off_q,
    output logic            ale,
    output logic            psen_n,
    output logic            rd_n,
    output logic            wr_n,
    output logic            drv_addr,
    output logic            drv_wdata
);
    function automatic logic in_win(input logic [PH_W-1:0] ph, input int lo, input int hi);
        return (ph >= PH_W'(lo)) && (ph < PH_W'(hi));
    endfunction

    logic ext;

    // Window decode per strobe; the latch strobe skips suppressed internal fetches.
    always_comb begin
        ext       = (kind != BK_INT_FETCH);
        ale       = busy && (ext || !off_q) && in_win(phase, 0, T_ALE_FALL);
        psen_n    = !(busy && kind == BK_EXT_FETCH && in_win(phase, T_PSEN_ON, T_PSEN_OFF));
        rd_n      = !(busy && kind == BK_DATA_RD && in_win(phase, T_RW_ON, T_RW_OFF));
        wr_n      = !(busy && kind == BK_DATA_WR && in_win(phase, T_RW_ON, T_RW_OFF));
        drv_addr  = busy && ext && in_win(phase, 0, T_ADDR_END);
        drv_wdata = busy && kind == BK_DATA_WR && in_win(phase, T_WD_ON, T_WD_OFF);
    end
endmodule

// File: rtl/ebus_data_path.sv
// Data path: holds the address and write byte of the running cycle,
// muxes the shared wires and captures the read byte at a fixed phase.
// Assumes AW > DW so a high address byte exists.
module ebus_data_path
    import ebus_pkg::*;
#(
    parameter int AW          = 16,
    parameter int DW          = 8,
    parameter int PH_W        = 4,
    parameter int T_CAP_FETCH = 5,
    parameter int T_CAP_RD    = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            accept,
    input  logic [AW-1:0]   req_addr,
    input  logic [DW-1:0]   req_wdata,
    input  logic            busy,
    input  logic [PH_W-1:0] phase,
    input  bus_kind_t       kind,
    input  logic            drv_addr,
    input  logic            drv_wdata,
    input  logic [DW-1:0]   ad_in,
    output logic [DW-1:0]   ad_out,
    output logic            ad_oe,
    output logic [AW-DW-1:0] addr_hi,
    output logic [DW-1:0]   rdata
);
    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdata_q;
    logic          cap;

    // Latch request fields at accept so they hold for the whole cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end
    end

    // Capture point: last clock of the fetch or read strobe.
    always_comb begin
        cap = busy && (((kind == BK_EXT_FETCH) && (phase == PH_W'(T_CAP_FETCH))) ||
                       ((kind == BK_DATA_RD)   && (phase == PH_W'(T_CAP_RD))));
    end

    // Read byte register.
    always_ff @(posedge clk) begin
        if (!rst_n) rdata <= '0;
        else if (cap) rdata <= ad_in;
    end

    // Shared-wire mux and high address byte.
    always_comb begin
        ad_oe   = drv_addr || drv_wdata;
        ad_out  = drv_addr ? addr_q[DW-1:0] : (drv_wdata ? wdata_q : '0);
        addr_hi = addr_q[AW-1:DW];
    end
endmodule

// File: rtl/ebus_seq.sv
// Top of the multiplexed external bus sequencer. Derives every phase
// offset from the clock-period timing parameters and wires the counter,
// strobe decoder and data path. Assumes one cycle at a time.
module ebus_seq
    import ebus_pkg::*;
#(
    parameter int AW          = 16,
    parameter int DW          = 8,
    parameter int ALE_HIGH    = 2,
    parameter int ADDR_HOLD   = 1,
    parameter int PSEN_DELAY  = 1,
    parameter int PSEN_LOW    = 3,
    parameter int RW_DELAY    = 3,
    parameter int RW_LOW      = 6,
    parameter int WDATA_SETUP = 1,
    parameter int WDATA_HOLD  = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [1:0]    req_kind,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic          ale_off,
    input  logic [DW-1:0] ad_in,
    output logic [DW-1:0] ad_out,
    output logic          ad_oe,
    output logic [AW-DW-1:0] addr_hi,
    output logic          ale,
    output logic          psen_n,
    output logic          rd_n,
    output logic          wr_n,
    output logic [DW-1:0] rdata,
    output logic          done
);
    localparam int T_ALE_FALL = ALE_HIGH;
    localparam int T_ADDR_END = T_ALE_FALL + ADDR_HOLD;
    localparam int T_PSEN_ON  = T_ALE_FALL + PSEN_DELAY;
    localparam int T_PSEN_OFF = T_PSEN_ON + PSEN_LOW;
    localparam int T_RW_ON    = T_ALE_FALL + RW_DELAY;
    localparam int T_RW_OFF   = T_RW_ON + RW_LOW;
    localparam int T_WD_ON    = T_RW_ON - WDATA_SETUP;
    localparam int T_WD_OFF   = T_RW_OFF + WDATA_HOLD;
    localparam int LAST_FETCH = T_PSEN_OFF;
    localparam int LAST_DATA  = (T_WD_OFF - 1 > T_RW_OFF) ? T_WD_OFF - 1 : T_RW_OFF;
    localparam int PH_W       = $clog2(LAST_DATA + 2);

    logic            accept;
    logic            busy;
    logic [PH_W-1:0] phase;
    bus_kind_t       kind;
    logic            off_q;
    logic            drv_addr;
    logic            drv_wdata;

    // Requests are taken only while idle.
    always_comb accept = req_valid && !busy;

    ebus_phase_ctr #(
        .PH_W(PH_W), .LAST_FETCH(LAST_FETCH), .LAST_DATA(LAST_DATA)
    ) u_ctr (
        .clk(clk), .rst_n(rst_n), .accept(accept),
        .req_kind(bus_kind_t'(req_kind)), .req_off(ale_off),
        .busy(busy), .phase(phase), .kind(kind), .off_q(off_q), .last(done)
    );

    ebus_strobe_gen #(
        .PH_W(PH_W), .T_ALE_FALL(T_ALE_FALL), .T_ADDR_END(T_ADDR_END),
        .T_PSEN_ON(T_PSEN_ON), .T_PSEN_OFF(T_PSEN_OFF),
        .T_RW_ON(T_RW_ON), .T_RW_OFF(T_RW_OFF),
        .T_WD_ON(T_WD_ON), .T_WD_OFF(T_WD_OFF)
    ) u_strb (
        .busy(busy), .phase(phase), .kind(kind), .off_q(off_q),
        .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n),
        .drv_addr(drv_addr), .drv_wdata(drv_wdata)
    );

    ebus_data_path #(
        .AW(AW), .DW(DW), .PH_W(PH_W),
        .T_CAP_FETCH(T_PSEN_OFF - 1), .T_CAP_RD(T_RW_OFF - 1)
    ) u_dp (
        .clk(clk), .rst_n(rst_n), .accept(accept),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .busy(busy), .phase(phase), .kind(kind),
        .drv_addr(drv_addr), .drv_wdata(drv_wdata), .ad_in(ad_in),
        .ad_out(ad_out), .ad_oe(ad_oe), .addr_hi(addr_hi), .rdata(rdata)
    );
endmodule

// File: rtl/ebus_seq_chk.sv
// Property checker for ebus_seq, attached with bind. Observes ports only.
module ebus_seq_chk #(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ale,
    input logic             psen_n,
    input logic             rd_n,
    input logic             wr_n,
    input logic             ad_oe,
    input logic [AW-DW-1:0] addr_hi,
    input logic             done
);
    // R4
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({~psen_n, ~rd_n, ~wr_n}));
    // R2
    ale_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> (psen_n && rd_n && wr_n));
    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R7
    wr_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |-> ad_oe);
    // R7
    wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_n) |-> ad_oe);
    // R4
    fetch_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(psen_n) |-> !ad_oe);
    // R6
    rd_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !ad_oe);
    // R9
    hi_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n && !$past(rd_n)) |-> $stable(addr_hi));
endmodule

bind ebus_seq ebus_seq_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .ale(ale), .psen_n(psen_n), .rd_n(rd_n),
    .wr_n(wr_n), .ad_oe(ad_oe), .addr_hi(addr_hi), .done(done)
);

// File: tb/sim_ebus_seq.sv
// Sweep bench for ebus_seq: every kind, both suppress settings, several
// addresses, with per-phase expectations computed from the timing offsets.
module sim_ebus_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = 2'd0;
    logic [15:0] req_addr = 16'h0;
    logic [7:0]  req_wdata = 8'h0;
    logic        ale_off = 1'b0;
    logic [7:0]  ad_in = 8'h0;
    logic [7:0]  ad_out;
    logic        ad_oe;
    logic [7:0]  addr_hi;
    logic        ale, psen_n, rd_n, wr_n, done;
    logic [7:0]  rdata;

    int n_cmp = 0;
    int n_bad = 0;
    logic [7:0] exp_rdata = 8'h00;

    ebus_seq u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_addr(req_addr), .req_wdata(req_wdata), .ale_off(ale_off),
        .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe), .addr_hi(addr_hi),
        .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n),
        .rdata(rdata), .done(done)
    );

    always #10 clk = ~clk;

    task automatic chk(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic idle_chk(input string tag);
        chk(tag, "ale idle", 16'(ale), 16'd0);
        chk(tag, "psen_n idle", 16'(psen_n), 16'd1);
        chk(tag, "rd_n idle", 16'(rd_n), 16'd1);
        chk(tag, "wr_n idle", 16'(wr_n), 16'd1);
        chk(tag, "ad_oe idle", 16'(ad_oe), 16'd0);
        chk(tag, "done idle", 16'(done), 16'd0);
    endtask

    task automatic run_cycle(input int k, input logic [15:0] a, input logic [7:0] wd,
                             input logic off, input logic [7:0] mem, input logic poke);
        int  last;
        logic ext, e_ale, e_psen, e_rd, e_wr, e_oe, e_done;
        logic [7:0] e_out;
        @(negedge clk);
        req_valid = 1'b1; req_kind = 2'(k); req_addr = a; req_wdata = wd;
        ale_off = off; ad_in = mem;
        @(negedge clk);
        req_valid = 1'b0;
        last = (k <= 1) ? 6 : 11;
        ext  = (k != 0);
        for (int p = 0; p <= last; p++) begin
            if (p > 0) @(negedge clk);
            if (poke && p == 3) begin
                req_valid = 1'b1; req_kind = 2'((k + 1) % 4); req_addr = ~a;
                req_wdata = ~wd; ale_off = ~off;
            end
            if (poke && p == 5) begin
                req_valid = 1'b0; req_addr = a; req_wdata = wd; ale_off = off;
            end
            e_ale  = (p < 2) && (ext || !off);
            e_psen = !(k == 1 && p >= 3 && p < 6);
            e_rd   = !(k == 2 && p >= 5 && p < 11);
            e_wr   = !(k == 3 && p >= 5 && p < 11);
            e_oe   = (ext && p < 3) || (k == 3 && p >= 4 && p < 12);
            e_out  = (ext && p < 3) ? a[7:0] : wd;
            e_done = (p == last);
            chk(poke ? "R11" : (k == 0 ? "R8" : "R2"), "ale", 16'(ale), 16'(e_ale));
            chk(poke ? "R11" : "R4", "psen_n", 16'(psen_n), 16'(e_psen));
            chk("R6", "rd_n", 16'(rd_n), 16'(e_rd));
            chk("R7", "wr_n", 16'(wr_n), 16'(e_wr));
            chk(k == 3 ? "R7" : "R3", "ad_oe", 16'(ad_oe), 16'(e_oe));
            if (e_oe) chk(k == 3 && p >= 4 ? "R7" : "R3", "ad_out", 16'(ad_out), 16'(e_out));
            chk("R10", "done", 16'(done), 16'(e_done));
            if (ext) chk(poke ? "R11" : "R9", "addr_hi", 16'(addr_hi), 16'(a[15:8]));
        end
        if (k == 1 || k == 2) exp_rdata = mem;
        @(negedge clk);
        idle_chk("R10");
        chk(k == 1 ? "R5" : (k == 2 ? "R6" : "R12"), "rdata", 16'(rdata), 16'(exp_rdata));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        idle_chk("R1");
        chk("R1", "rdata reset", 16'(rdata), 16'h00);
        rst_n = 1'b1;
        @(negedge clk);
        idle_chk("R1");
        for (int i = 0; i < 4; i++) begin
            for (int k = 0; k < 4; k++) begin
                for (int o = 0; o < 2; o++) begin
                    logic [15:0] a;
                    a = (i == 0) ? 16'h0000 : (i == 1) ? 16'hFFFF : 16'(16'h1357 * (i + k + o));
                    run_cycle(k, a, 8'(8'h3C ^ (i * 16 + k * 4 + o)), o[0],
                              8'(8'hA5 + i * 7 + k * 3 + o), (i == 2));
                end
            end
        end
        // R12: back-to-back write then internal fetch keep the last read byte
        run_cycle(2, 16'hBEEF, 8'h11, 1'b1, 8'h6E, 1'b0);
        run_cycle(3, 16'hCAFE, 8'h22, 1'b0, 8'h99, 1'b0);
        run_cycle(0, 16'h0F0F, 8'h33, 1'b1, 8'h44, 1'b0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(20 * 100000);
        n_bad++;
        $display("FAIL watchdog: actual expired expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule